// File: doc/BRIEF.md
# Bufferless Five-Port Mesh Circuit Switch

This block is the switching element of one node in a two-dimensional mesh. It has five ports: four face the neighbouring nodes (north, east, south, west), and one faces the local core. Each port carries a stream in each direction. A stream has a data word, a valid bit, and a request bit that travels against the data. The request bit is the back-pressure signal: a receiver raises it to ask its sender for the next word. Nothing is stored inside the switch. Data and valid go straight from the chosen input to an output through combinational logic. The request that arrives on that output goes straight back to the same input, so the flow-control rules of the sender and the receiver meet end to end across the node.

Each output has its own selector, a small crossbar slice. The slice is steered by a 3-bit field of a configuration word. A sixth field says where the core's returning handshake comes from. Nothing is decoded from the traffic and nothing is arbitrated. The word is written from outside while the switch is halted (`ready` low). Traffic resumes when `ready` goes high again.

Top module: `mesh_cs_router`

## Requirements
- R1: After reset, the configuration holds the idle code 3'b111 in every field. All outputs therefore show valid 0 and data 0, and every returned request is 0, even with `ready` high and traffic offered.
- R2: Port codes are north 0, east 1, south 2, west 3 and core 4. The configuration word has six fields: reserve in bits [17:15], north output in [14:12], east in [11:9], south in [8:6], west in [5:3] and core in [2:0]. Port p's lane in the flat data buses is bits [p*DATA_W +: DATA_W].
- R3: When `ready` is high and an output's field holds a code from 0 to 4, that output's data and valid equal the named input's data and valid in the same cycle.
- R4: A field code of 5, 6 or 7 leaves its output idle, with data 0 and valid 0, and routes no request anywhere.
- R5: When `ready` is high, the request returned to a non-core input is the OR of the requests that arrive on every output whose field names that input. The same rule applies to the core input while the reserve field holds 5 to 7.
- R6: When the reserve field holds a code from 0 to 4 and `ready` is high, the request returned to the core input equals the request that arrives on the output named by the reserve field.
- R7: While `ready` is low, every output drives data 0 and valid 0, and every returned request is 0.
- R8: A clock edge with `cfg_load` high and `ready` low captures `cfg_word`. The new routing applies from the cycle after that edge.
- R9: `cfg_load` while `ready` is high is ignored, and the routing stays as it was.
- R10: All five outputs can carry traffic at the same time, whether the inputs are permuted or one input fans out to several outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 1 | High: switch routes traffic. Low: halted, and configuration may be loaded |
| cfg_load | input | 1 | Load strobe for the configuration word |
| cfg_word | input | 18 | Configuration word (field layout in R2) |
| in_data | input | 5*DATA_W | Incoming data, one lane per port |
| in_valid | input | 5 | Incoming valid, one bit per port |
| in_req | output | 5 | Request returned upstream on each input port |
| out_data | output | 5*DATA_W | Outgoing data, one lane per port |
| out_valid | output | 5 | Outgoing valid, one bit per port |
| out_req | input | 5 | Request arriving from downstream on each output port |

## Verification
The assertions take for granted that `ready`, `cfg_load` and `cfg_word` change only just after a rising clock edge. This lets the configuration register's capture and hold rules be checked at each edge. They also assume the data-path inputs are settled when the edge samples them, because the switching paths are combinational. The stimulus changes every input one time unit after the rising edge and compares outputs at the falling edge. Loads are made only through a task that lowers `ready` in the same step. One phase deliberately strobes `cfg_load` while `ready` is high, to exercise the ignore rule.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORTS = 5;
  localparam int ID_W   = 3;
  localparam int CFG_W  = (NPORTS + 1) * ID_W;

  typedef enum logic [ID_W-1:0] {
    PID_NORTH = 3'd0,
    PID_EAST  = 3'd1,
    PID_SOUTH = 3'd2,
    PID_WEST  = 3'd3,
    PID_CORE  = 3'd4
  } port_id_e;

  localparam logic [ID_W-1:0] PID_IDLE = '1;
  localparam int CORE_IDX = int'(PID_CORE);

  // Field of output o sits below the reserve field, north first.
  function automatic logic [ID_W-1:0] out_field(input logic [CFG_W-1:0] cfg, input int o);
    return cfg[(NPORTS-1-o)*ID_W +: ID_W];
  endfunction

  function automatic logic [ID_W-1:0] rsv_field(input logic [CFG_W-1:0] cfg);
    return cfg[NPORTS*ID_W +: ID_W];
  endfunction
endpackage

// File: rtl/rtr_cfg_reg.sv
module rtr_cfg_reg
  import router_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ready,
  input  logic         load,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cfg_q <= '1;
    else if (load && !ready) cfg_q <= word_i;
  end

  assign cfg_o = cfg_q;

  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ready) |=> (cfg_q == $past(word_i))); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/rtr_out_xbar.sv
module rtr_out_xbar
  import router_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NP     = NPORTS,
  parameter int IDW    = ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ready,
  input  logic [IDW-1:0]       sel,
  input  logic [NP*DATA_W-1:0] in_data,
  input  logic [NP-1:0]        in_valid,
  input  logic                 ret_req,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_valid,
  output logic [NP-1:0]        req_fwd
);
  always_comb begin
    out_data  = '0;
    out_valid = 1'b0;
    req_fwd   = '0;
    for (int p = 0; p < NP; p++) begin
      if (ready && sel == IDW'(p)) begin
        out_data   = in_data[p*DATA_W +: DATA_W];
        out_valid  = in_valid[p];
        req_fwd[p] = ret_req;
      end
    end
  end

  AST_IDLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NP) |-> (!out_valid && out_data == '0 && req_fwd == '0)); // R4
  AST_REQ_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_fwd)); // R5
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!out_valid && out_data == '0)); // R7
endmodule

// File: rtl/rtr_req_merge.sv
module rtr_req_merge
  import router_pkg::*;
#(
  parameter int NP  = NPORTS,
  parameter int IDW = ID_W,
  parameter int CI  = CORE_IDX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [IDW-1:0]   rsv,
  input  logic [NP*NP-1:0] req_mat,
  input  logic [NP-1:0]    out_req,
  output logic [NP-1:0]    in_req
);
  logic rsv_hit;
  assign rsv_hit = int'(rsv) < NP;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      in_req[p] = 1'b0;
      for (int o = 0; o < NP; o++) in_req[p] = in_req[p] | req_mat[o*NP + p];
    end
    if (rsv_hit) begin
      in_req[CI] = 1'b0;
      for (int o = 0; o < NP; o++)
        if (rsv == IDW'(o)) in_req[CI] = ready & out_req[o];
    end
  end

  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (in_req == '0)); // R7
  AST_RESERVE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rsv_hit) |-> (in_req[CI] == out_req[rsv])); // R6
endmodule

// File: rtl/mesh_cs_router.sv
module mesh_cs_router
  import router_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ready,
  input  logic                     cfg_load,
  input  logic [CFG_W-1:0]         cfg_word,
  input  logic [NPORTS*DATA_W-1:0] in_data,
  input  logic [NPORTS-1:0]        in_valid,
  output logic [NPORTS-1:0]        in_req,
  output logic [NPORTS*DATA_W-1:0] out_data,
  output logic [NPORTS-1:0]        out_valid,
  input  logic [NPORTS-1:0]        out_req
);
  localparam int NP = NPORTS;

  logic [CFG_W-1:0] cfg;
  logic [NP*NP-1:0] req_mat;

  rtr_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ready(ready), .load(cfg_load),
    .word_i(cfg_word), .cfg_o(cfg)
  );

  for (genvar o = 0; o < NP; o++) begin : g_out
    rtr_out_xbar #(.DATA_W(DATA_W), .NP(NP), .IDW(ID_W)) u_xbar (
      .clk(clk), .rst_n(rst_n), .ready(ready),
      .sel(out_field(cfg, o)),
      .in_data(in_data), .in_valid(in_valid),
      .ret_req(out_req[o]),
      .out_data(out_data[o*DATA_W +: DATA_W]),
      .out_valid(out_valid[o]),
      .req_fwd(req_mat[o*NP +: NP])
    );
  end

  rtr_req_merge #(.NP(NP), .IDW(ID_W), .CI(CORE_IDX)) u_merge (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .rsv(rsv_field(cfg)), .req_mat(req_mat),
    .out_req(out_req), .in_req(in_req)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0 && in_req == '0)); // R1
endmodule

// File: tb/test_mesh_cs_router.sv
module test_mesh_cs_router;
  localparam int DW = 8;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready = 1'b1;
  logic cfg_load = 1'b0;
  logic [17:0] cfg_word = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0] in_valid = '0;
  logic [NP-1:0] in_req;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_req = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit comparing = 0;
  string phase = "R1";
  logic [17:0] mcfg;

  always #10 clk = ~clk;

  mesh_cs_router #(.DATA_W(DW)) i_mesh_cs_router (
    .clk(clk), .rst_n(rst_n), .ready(ready), .cfg_load(cfg_load),
    .cfg_word(cfg_word), .in_data(in_data), .in_valid(in_valid),
    .in_req(in_req), .out_data(out_data), .out_valid(out_valid),
    .out_req(out_req)
  );

  // Reference configuration: R8 capture, R9 ignore, R1 reset value.
  always @(posedge clk) begin
    if (!rst_n) mcfg <= '1;
    else if (cfg_load && !ready) mcfg <= cfg_word;
  end

  function automatic int fld(input logic [17:0] c, input int o);
    return int'(c[(4-o)*3 +: 3]);  // R2 layout
  endfunction

  task automatic check(input string tag, input string what, input int idx,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s[%0d] actual %h expected %h", tag, what, idx, act, exp);
    end
  endtask

  // Per-cycle comparison against the behavioural model.
  always @(negedge clk) begin
    if (comparing) begin
      int rsv;
      rsv = int'(mcfg[17:15]);
      for (int o = 0; o < NP; o++) begin
        int f;
        logic [DW-1:0] ed;
        logic ev;
        string t;
        f = fld(mcfg, o);
        ed = '0; ev = 1'b0;
        if (!ready) t = "R7";
        else if (f > 4) t = "R4";
        else begin
          t = "R3"; ed = in_data[f*DW +: DW]; ev = in_valid[f];
        end
        check({phase, "/", t}, "out_data", o, out_data[o*DW +: DW], ed);
        check({phase, "/", t}, "out_valid", o, DW'(out_valid[o]), DW'(ev));
      end
      for (int p = 0; p < NP; p++) begin
        logic er;
        string t;
        er = 1'b0;
        if (!ready) t = "R7";
        else if (p == 4 && rsv <= 4) begin
          t = "R6"; er = out_req[rsv];
        end else begin
          t = "R5";
          for (int o = 0; o < NP; o++) if (fld(mcfg, o) == p) er = er | out_req[o];
        end
        check({phase, "/", t}, "in_req", p, DW'(in_req[p]), DW'(er));
      end
    end
  end

  function automatic logic [17:0] mk(input int r, input int n, input int e,
                                     input int s, input int w, input int c);
    return {3'(r), 3'(n), 3'(e), 3'(s), 3'(w), 3'(c)};
  endfunction

  task automatic load_cfg(input logic [17:0] w);
    @(posedge clk); #1;
    ready = 1'b0; cfg_load = 1'b1; cfg_word = w;
    @(posedge clk); #1;
    cfg_load = 1'b0; ready = 1'b1;
  endtask

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_data  = {$urandom(), $urandom()};
      in_valid = 5'($urandom());
      out_req  = 5'($urandom());
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    comparing = 1'b1;
    // R1: idle after reset with traffic offered
    phase = "R1";
    in_valid = '1; out_req = '1; in_data = '1;
    @(negedge clk);
    check("R1", "out_valid_all", 0, DW'(out_valid), '0);
    traffic(4);

    // R3 / R10: full permutation, every output active
    phase = "R10";
    load_cfg(mk(7, 2, 3, 0, 1, 4));
    @(posedge clk); #1 in_valid = '1; in_data = 40'h5544332211;
    @(negedge clk);
    check("R10", "out_valid_all", 0, DW'(out_valid), 8'h1f);
    check("R10", "north_from_south", 0, out_data[7:0], 8'h33);
    traffic(10);

    // R10: multicast of core to all outputs
    load_cfg(mk(7, 4, 4, 4, 4, 4));
    traffic(10);

    // R4: idle codes on several outputs
    phase = "R4";
    load_cfg(mk(7, 5, 6, 7, 0, 1));
    traffic(10);

    // R5 / R6: reserve field routing core handshake
    phase = "R6";
    load_cfg(mk(1, 4, 0, 4, 2, 3));
    @(posedge clk); #1 out_req = 5'b00010;
    @(negedge clk);
    check("R6", "core_req", 4, DW'(in_req[4]), 8'd1);
    traffic(10);
    phase = "R5";
    load_cfg(mk(6, 4, 0, 4, 2, 3));
    traffic(10);

    // R9: strobe while running must not change routing
    phase = "R9";
    @(posedge clk); #1 cfg_load = 1'b1; cfg_word = mk(7, 7, 7, 7, 7, 7);
    @(posedge clk); #1 cfg_load = 1'b0; in_valid = '1;
    @(negedge clk);
    check("R9", "north_still_routed", 0, DW'(out_valid[0]), 8'd1);
    traffic(6);

    // R7: halted outputs quiet
    phase = "R7";
    @(posedge clk); #1 ready = 1'b0; in_valid = '1; out_req = '1;
    @(negedge clk);
    check("R7", "out_valid_all", 0, DW'(out_valid), '0);
    check("R7", "in_req_all", 0, DW'(in_req), '0);
    @(posedge clk); #1 ready = 1'b1;

    // R8 / R2: random configurations
    phase = "R8";
    for (int k = 0; k < 30; k++) begin
      load_cfg(18'($urandom()));
      traffic(5);
    end
    @(negedge clk);
    comparing = 1'b0;
    finish_run();
  end
endmodule